// File: doc/BRIEF.md
# MDIO Multi-Bus Management Master

This block is a register-mapped management master for PHY devices. It owns one frame engine that can be steered onto any one of several MDIO buses, which are split into an internal group and an external group of equal size. Software fills in a parameter word (group, bus id, PHY address, write data, framing mode) and a register address. It then writes an opcode to the control register and polls a done flag. When the flag is set, read data is waiting in its own register.

The engine produces MDC from the core clock. Each group has its own rate word, so the two groups can run at different management clock speeds. Both Clause-22 and Clause-45 framing are supported; a Clause-45 access is sent as an address frame followed by the data frame. Software maps logical bus numbers 0 to 15 onto the internal group with the same id, and numbers 16 and up onto the external group with id equal to the number minus 16. A bit in the scan-control word is brought out as an output that locks any other MDIO master off the buses.

Top module: `mdio_mux_master`

## Requirements
- R1: Register offsets (byte addresses) are: external rate 0x000, internal rate 0x004, scan control 0x008, parameter 0x23C, read data 0x240, register address 0x244, control 0x248, status 0x24C. The rate, scan, parameter and address words read back the value last written. After reset every register reads 0.
- R2: Writing 1 to control starts a write and writing 2 starts a read. Writing 0 stops the engine and clears the done flag, which is status bit 0. Done reads 1 once a started access has finished. A nonzero control write while the engine is busy is ignored and leaves the frame in flight unchanged.
- R3: A Clause-22 frame is sent MSB first as 32 ones, start 01, opcode (01 write, 10 read), PHY address from parameter[20:16], register address from address[4:0], turnaround 10, then 16 data bits from parameter[15:0].
- R4: In a read frame, MDIO output-enable is low from the turnaround through the end of the frame, so only the first 46 bits are driven. The 16 data bits are sampled on rising MDC and appear in read data [15:0] when done is set.
- R5: When parameter bit 21 is set, the access is Clause-45. First comes an address frame: ones, start 00, opcode 00, PHY address, device address from address[20:16], turnaround 10, then address[15:0]. Then comes a data frame with start 00, opcode 01 for a write or 11 for a read, and the same PHY and device addresses.
- R6: The MDC half-period in core clocks is rate[15:0] × (rate[23:16] + 1), with a minimum of 1. The internal group uses the rate at 0x004 and the external group uses the rate at 0x000. MDC idles low. Data changes on the falling edge.
- R7: Parameter bit 25 set selects the internal group and clear selects the external group. Parameter[24:22] is the bus id. Only the selected bus toggles MDC or enables MDIO. Every other bus, and every bus while idle, holds MDC low with output-enable low.
- R8: Scan-control bit 28 drives the ext_master_block output.
- R9: If a control write of 0 lands in the same cycle as the final falling MDC edge of an access, the clear wins. Done reads 0 afterwards and MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ext_master_block | output | 1 | Locks out other MDIO masters |
| int_mdc | output | NBUS | MDC of each internal bus |
| int_mdio_o | output | NBUS | MDIO output value, internal buses |
| int_mdio_oe | output | NBUS | MDIO output enable, internal buses |
| int_mdio_i | input | NBUS | MDIO input, internal buses |
| ext_mdc | output | NBUS | MDC of each external bus |
| ext_mdio_o | output | NBUS | MDIO output value, external buses |
| ext_mdio_oe | output | NBUS | MDIO output enable, external buses |
| ext_mdio_i | input | NBUS | MDIO input, external buses |

## Verification
Two events can fall on the same clock edge: a software clear of the control register and the engine finishing a frame on its last falling MDC edge. The bench starts a Clause-22 write at the fastest rate, counts the clocks to that final edge, and places a control write of 0 on that exact edge. The pass condition is that the complete frame was seen on the bus, that done then reads 0, and that MDC stays quiet on every bus. A second overlap is covered as well: a start opcode and a parameter rewrite are issued while a frame is in flight, and the scoreboard confirms the frame still carries its original contents.

// File: rtl/mdio_mux_master.sv
module mdio_mux_master #(
  parameter int NBUS = 8,
  parameter int AW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            ext_master_block,
  output logic [NBUS-1:0] int_mdc,
  output logic [NBUS-1:0] int_mdio_o,
  output logic [NBUS-1:0] int_mdio_oe,
  input  logic [NBUS-1:0] int_mdio_i,
  output logic [NBUS-1:0] ext_mdc,
  output logic [NBUS-1:0] ext_mdio_o,
  output logic [NBUS-1:0] ext_mdio_oe,
  input  logic [NBUS-1:0] ext_mdio_i
);
  localparam logic [AW-1:0] A_REXT = AW'('h000);
  localparam logic [AW-1:0] A_RINT = AW'('h004);
  localparam logic [AW-1:0] A_SCAN = AW'('h008);
  localparam logic [AW-1:0] A_PARM = AW'('h23C);
  localparam logic [AW-1:0] A_RDAT = AW'('h240);
  localparam logic [AW-1:0] A_ADDR = AW'('h244);
  localparam logic [AW-1:0] A_CTRL = AW'('h248);
  localparam logic [AW-1:0] A_STAT = AW'('h24C);

  logic [31:0] rate_ext, rate_int, scan, param, addr_r;
  logic [15:0] rd_r, rx;
  logic        running, done, grp, rdf, rdsave, pend, mdc;
  logic [2:0]  bid;
  logic [5:0]  bitcnt;
  logic [63:0] frm, frm2;
  logic [24:0] cnt, prod, half;

  wire [31:0] rsel = grp ? rate_int : rate_ext;
  assign prod = 25'(rsel[15:0]) * 25'({1'b0, rsel[23:16]} + 9'd1);
  assign half = (prod == '0) ? 25'd1 : prod;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire start   = wr_ctrl && !running && (reg_wdata == 32'd1 || reg_wdata == 32'd2);
  wire clr     = wr_ctrl && reg_wdata == 32'd0;
  wire isrd    = reg_wdata[1];
  wire c45     = param[21];

  wire [4:0]  ra    = c45 ? addr_r[20:16] : addr_r[4:0];
  wire [15:0] wdat  = isrd ? 16'h0 : param[15:0];
  wire [63:0] f_c22  = {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, param[20:16], ra, 2'b10, wdat};
  wire [63:0] f_c45a = {32'hFFFF_FFFF, 4'b0000, param[20:16], ra, 2'b10, addr_r[15:0]};
  wire [63:0] f_c45b = {32'hFFFF_FFFF, 2'b00, isrd ? 2'b11 : 2'b01, param[20:16], ra, 2'b10, wdat};

  wire mdio_in = grp ? int_mdio_i[bid] : ext_mdio_i[bid];
  wire oe      = !(rdf && bitcnt >= 6'd46);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_ext <= '0; rate_int <= '0; scan <= '0; param <= '0; addr_r <= '0;
      rd_r <= '0; rx <= '0; running <= 1'b0; done <= 1'b0; grp <= 1'b0;
      rdf <= 1'b0; rdsave <= 1'b0; pend <= 1'b0; mdc <= 1'b0; bid <= '0;
      bitcnt <= '0; frm <= '0; frm2 <= '0; cnt <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_REXT: rate_ext <= reg_wdata;
          A_RINT: rate_int <= reg_wdata;
          A_SCAN: scan     <= reg_wdata;
          A_PARM: param    <= reg_wdata;
          A_ADDR: addr_r   <= reg_wdata;
          default: ;
        endcase
      end
      if (running) begin
        if (cnt >= half - 25'd1) begin
          cnt <= '0;
          mdc <= ~mdc;
          if (!mdc) begin
            if (rdf && bitcnt >= 6'd48) rx <= {rx[14:0], mdio_in};
          end else begin
            frm    <= {frm[62:0], 1'b0};
            bitcnt <= bitcnt + 6'd1;
            if (bitcnt == 6'd63) begin
              if (pend) begin
                pend <= 1'b0;
                frm  <= frm2;
                rdf  <= rdsave;
              end else begin
                running <= 1'b0;
                done    <= 1'b1;
                if (rdf) rd_r <= rx;
              end
            end
          end
        end else begin
          cnt <= cnt + 25'd1;
        end
      end
      if (start) begin
        running <= 1'b1; done <= 1'b0; cnt <= '0; mdc <= 1'b0; bitcnt <= '0;
        grp <= param[25]; bid <= param[24:22]; pend <= c45;
        frm <= c45 ? f_c45a : f_c22; frm2 <= f_c45b;
        rdf <= c45 ? 1'b0 : isrd; rdsave <= isrd;
      end
      if (clr) begin
        running <= 1'b0; done <= 1'b0; mdc <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    wire sel_i = running && int'(bid) == i;
    assign int_mdc[i]     = sel_i && grp && mdc;
    assign int_mdio_oe[i] = sel_i && grp && oe;
    assign int_mdio_o[i]  = sel_i && grp && frm[63];
    assign ext_mdc[i]     = sel_i && !grp && mdc;
    assign ext_mdio_oe[i] = sel_i && !grp && oe;
    assign ext_mdio_o[i]  = sel_i && !grp && frm[63];
  end

  assign ext_master_block = scan[28];

  always_comb begin
    case (reg_addr)
      A_REXT:  reg_rdata = rate_ext;
      A_RINT:  reg_rdata = rate_int;
      A_SCAN:  reg_rdata = scan;
      A_PARM:  reg_rdata = param;
      A_RDAT:  reg_rdata = {16'h0, rd_r};
      A_ADDR:  reg_rdata = addr_r;
      A_STAT:  reg_rdata = {31'h0, done};
      default: reg_rdata = 32'h0;
    endcase
  end

  a_r7_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_mdc, ext_mdc}));
  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({int_mdc, ext_mdc, int_mdio_oe, ext_mdio_oe} == '0));
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);
  a_r2_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !done);
  a_r2_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(running));
endmodule

// File: tb/mdio_mux_master_bench.sv
module mdio_mux_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ext_master_block;
  logic [7:0] int_mdc, int_o, int_oe, int_mi, ext_mdc, ext_o, ext_oe, ext_mi;

  always #2.5 clk = ~clk;

  mdio_mux_master u_mdio_mux_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_master_block(ext_master_block),
    .int_mdc(int_mdc), .int_mdio_o(int_o), .int_mdio_oe(int_oe), .int_mdio_i(int_mi),
    .ext_mdc(ext_mdc), .ext_mdio_o(ext_o), .ext_mdio_oe(ext_oe), .ext_mdio_i(ext_mi));

  typedef struct packed {
    logic [3:0]  bus;
    logic [63:0] d;
    logic [63:0] m;
    int          h;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  logic [63:0] rdpat = '0;
  logic [31:0] rate_i = '0, rate_e = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [63:0] cur_d = '0, cur_m = '0;
  int nbits = 0, hrun = 0, lasth = 0, cur_bus = 0;
  bit prev_h = 1'b0;

  always @(negedge clk) begin
    logic [15:0] mv, ov, dv;
    bit anyh, bitv;
    item_t e;
    mv = {ext_mdc, int_mdc}; ov = {ext_oe, int_oe}; dv = {ext_o, int_o};
    anyh = |mv;
    if ($countones(mv) > 1) chk(0, "R7 multiple MDC", 64'(mv), 0);
    if (anyh && !prev_h) begin
      for (int k = 0; k < 16; k++) if (mv[k]) cur_bus = k;
      cur_d = {cur_d[62:0], dv[cur_bus]};
      cur_m = {cur_m[62:0], ov[cur_bus]};
      nbits++;
      hrun = 1;
    end else if (anyh) hrun++;
    if ((ov & ~(16'd1 << cur_bus)) != 0 && nbits > 0) chk(0, "R7 stray enable", 64'(ov), 0);
    if (!anyh && prev_h) begin
      lasth = hrun;
      if (nbits == 64) begin
        if (q.size() == 0) chk(0, "R2 unexpected frame", cur_d, 0);
        else begin
          e = q.pop_front();
          chk(cur_bus == int'(e.bus), "R7 bus", 64'(cur_bus), 64'(e.bus));
          chk(cur_m == e.m, "R4 enable mask", cur_m, e.m);
          chk((cur_d & e.m) == (e.d & e.m), "R3/R5 frame bits", cur_d & e.m, e.d & e.m);
          chk(lasth == e.h, "R6 half period", 64'(lasth), 64'(e.h));
        end
        nbits = 0;
      end
    end
    prev_h = anyh;
    bitv = (nbits < 64) ? rdpat[63 - nbits] : 1'b0;
    int_mi = {8{bitv}};
    ext_mi = {8{bitv}};
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int half_of(input logic [31:0] r);
    int p;
    p = int'(r[15:0]) * (int'(r[23:16]) + 1);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic push_frames(input int lbus, input logic [4:0] phy, input logic [20:0] ra,
                             input bit c45, input bit isrd, input logic [15:0] wd);
    item_t e;
    logic [3:0] bus;
    int h;
    logic [15:0] dat;
    bus = (lbus < 16) ? 4'(lbus) : 4'(lbus - 16 + 8);
    h = half_of((lbus < 16) ? rate_i : rate_e);
    dat = isrd ? 16'h0 : wd;
    if (c45) begin
      e.bus = bus; e.h = h; e.m = '1;
      e.d = {32'hFFFF_FFFF, 4'b0000, phy, ra[20:16], 2'b10, ra[15:0]};
      q.push_back(e);
      e.d = {32'hFFFF_FFFF, 2'b00, isrd ? 2'b11 : 2'b01, phy, ra[20:16], 2'b10, dat};
    end else begin
      e.bus = bus; e.h = h;
      e.d = {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, phy, ra[4:0], 2'b10, dat};
    end
    e.m = isrd ? 64'hFFFF_FFFF_FFFC_0000 : '1;
    q.push_back(e);
  endtask

  function automatic logic [31:0] param_of(input int lbus, input logic [4:0] phy,
                                           input bit c45, input logic [15:0] wd);
    logic [2:0] id;
    id = (lbus < 16) ? 3'(lbus) : 3'(lbus - 16);
    return {6'h0, (lbus < 16), id, c45, phy, wd};
  endfunction

  task automatic do_op(input int lbus, input logic [4:0] phy, input logic [20:0] ra,
                       input bit c45, input bit isrd, input logic [15:0] wd, input logic [15:0] rv);
    logic [31:0] d;
    bit seen;
    rdpat = {48'h0, rv};
    wr(10'h23C, param_of(lbus, phy, c45, wd));
    wr(10'h244, 32'(ra));
    wr(10'h248, 32'd0);
    rd(10'h24C, d);
    chk(d[0] == 1'b0, "R2 done after clear", 64'(d[0]), 0);
    push_frames(lbus, phy, ra, c45, isrd, wd);
    wr(10'h248, isrd ? 32'd2 : 32'd1);
    seen = 1'b0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      rd(10'h24C, d);
      seen = d[0];
    end
    chk(seen, "R2 done set", 64'(seen), 1);
    if (isrd) begin
      rd(10'h240, d);
      chk(d == {16'h0, rv}, "R4 read data", 64'(d), 64'(rv));
    end
    repeat (4) @(posedge clk);
    chk(q.size() == 0, "R2 frames consumed", 64'(q.size()), 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int_mi = '0; ext_mi = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state R1 R7 R8
    rd(10'h24C, d); chk(d == 0, "R1 status at reset", 64'(d), 0);
    rd(10'h23C, d); chk(d == 0, "R1 param at reset", 64'(d), 0);
    chk({int_mdc, ext_mdc, int_oe, ext_oe} == 0, "R7 idle at reset", 64'({int_mdc, ext_mdc}), 0);
    chk(ext_master_block == 0, "R8 reset", 64'(ext_master_block), 0);
    // R1 readback, R6 minimum half period via zero divisor
    rate_e = 32'h0000_0000; rate_i = 32'h0000_0001;
    wr(10'h000, rate_e); wr(10'h004, rate_i);
    wr(10'h244, 32'h0015_4321);
    rd(10'h004, d); chk(d == rate_i, "R1 int rate readback", 64'(d), 64'(rate_i));
    rd(10'h244, d); chk(d == 32'h0015_4321, "R1 address readback", 64'(d), 64'h154321);
    wr(10'h23C, 32'h02AB_CDEF);
    rd(10'h23C, d); chk(d == 32'h02AB_CDEF, "R1 param readback", 64'(d), 64'h2ABCDEF);
    // R3 Clause-22 write on internal bus 3
    do_op(3, 5'd5, 21'h11, 1'b0, 1'b0, 16'hA5C3, 16'h0);
    // R4 Clause-22 read on external bus 5 (logical 21)
    do_op(21, 5'd9, 21'h1E, 1'b0, 1'b1, 16'h0, 16'h3C5A);
    // R5 Clause-45 write on external bus 2, read on internal bus 7
    do_op(18, 5'd3, 21'h07_1234, 1'b1, 1'b0, 16'hBEEF, 16'h0);
    do_op(7, 5'd31, 21'h1F_8001, 1'b1, 1'b1, 16'h0, 16'h8001);
    // R6 per-group rates: internal half 6, external stays 1
    rate_i = 32'h0001_0003;
    wr(10'h004, rate_i);
    do_op(0, 5'd1, 21'h02, 1'b0, 1'b0, 16'h1357, 16'h0);
    do_op(16, 5'd2, 21'h03, 1'b0, 1'b1, 16'h0, 16'hF00D);
    // R2 start and parameter rewrite while busy are ignored
    rate_i = 32'h0000_0001;
    wr(10'h004, rate_i);
    wr(10'h23C, param_of(4, 5'd6, 1'b0, 16'h2468));
    wr(10'h244, 32'h0A);
    wr(10'h248, 32'd0);
    push_frames(4, 5'd6, 21'h0A, 1'b0, 1'b0, 16'h2468);
    wr(10'h248, 32'd1);
    repeat (10) @(posedge clk);
    wr(10'h23C, param_of(20, 5'd1, 1'b0, 16'hFFFF));
    wr(10'h248, 32'd2);
    repeat (200) @(posedge clk);
    rd(10'h24C, d); chk(d[0] == 1'b1, "R2 busy start ignored, done", 64'(d[0]), 1);
    chk(q.size() == 0, "R2 single frame", 64'(q.size()), 0);
    // R9 clear collides with final falling edge (half 1: done edge is 128 after start)
    wr(10'h23C, param_of(4, 5'd6, 1'b0, 16'h2468));
    wr(10'h248, 32'd0);
    push_frames(4, 5'd6, 21'h0A, 1'b0, 1'b0, 16'h2468);
    wr(10'h248, 32'd1);
    repeat (127) @(posedge clk);
    wr(10'h248, 32'd0);
    repeat (4) @(posedge clk);
    rd(10'h24C, d); chk(d[0] == 1'b0, "R9 clear wins", 64'(d[0]), 0);
    chk({int_mdc, ext_mdc} == 0, "R9 MDC quiet", 64'({int_mdc, ext_mdc}), 0);
    chk(q.size() == 0, "R9 frame seen", 64'(q.size()), 0);
    // R8 override bit
    wr(10'h008, 32'h1000_0000);
    @(negedge clk);
    chk(ext_master_block == 1'b1, "R8 override set", 64'(ext_master_block), 1);
    rd(10'h008, d); chk(d == 32'h1000_0000, "R1 scan readback", 64'(d), 64'h10000000);
    wr(10'h008, 32'h0);
    @(negedge clk);
    chk(ext_master_block == 1'b0, "R8 override clear", 64'(ext_master_block), 0);
    chk({int_mdc, ext_mdc, int_oe, ext_oe} == 0, "R7 idle at end", 64'({int_oe, ext_oe}), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule